// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor-side request port and a cache controller. It records every memory request that is in flight. Each request is keyed by its cache-line address, which is the byte address with the in-line offset bits removed. Requests that read memory go into a read table. Requests that write memory or need ownership of the line go into a write table. Both tables are small associative arrays. For every presented request the block answers in the same cycle with one of four codes: accepted, refused because the line is already in flight, refused because there is no room, or refused because the access crosses the end of the line.

An accepted request receives a sequence number and has its issue cycle recorded. It is forwarded downstream one cycle later. When the controller returns a completion, it names the table and the line. The block then frees the matching entry and reports the stored sequence number together with the latency in cycles. A completion that matches nothing raises an error pulse and changes nothing.

A periodic age check runs only while something is outstanding. It raises a sticky hang flag when any entry has waited too long.

Top module: `inflight_tracker`

## Requirements
- R1: Request kinds 2 (store), 3 (atomic read), 4 (atomic write), 5 (locked read) and 6 (locked write) are held in the write table. Kinds 0 (load), 1 (instruction fetch) and 7 are held in the read table. A completion must name the table that holds its entry (`cpl_is_write`=1 for the write table).
- R2: The line address is `req_addr[ADDR_W-1:OFF_W]`. A request whose line is present in either table gets `rsp_status`=1 (aliased) and no entry is allocated.
- R3: A request gets `rsp_status`=2 (full) when the outstanding count is at least `MAX_OUT`, or when its target table has no free entry.
- R4: A request whose offset plus `req_len` exceeds 2^`OFF_W` bytes gets `rsp_status`=3. The priority is size error, then aliased, then full. `rsp_status`=0 means accepted. The status is combinational while `req_valid` is high.
- R5: A request accepted at a clock edge appears on `dn_valid`/`dn_kind`/`dn_line`/`dn_id` for exactly one cycle after that edge.
- R6: Sequence numbers start at 0 after reset and rise by one per accepted request. `rsp_id` shows the number that an accept would take.
- R7: A completion that matches an entry frees it. In the following cycle `done_valid` pulses with the stored number on `done_id`, and `done_lat` equals the number of clock edges from the accepting edge to the completing edge.
- R8: A completion that matches no entry in the named table pulses `cpl_err` in the following cycle. It produces no `done_valid` and leaves every entry in place.
- R9: The outstanding count always equals the read-table occupancy plus the write-table occupancy, and never exceeds `MAX_OUT`.
- R10: While at least one entry is outstanding, the age of every entry is examined every `THRESH` cycles. If any age is at least `THRESH`, `hang` goes high and stays high until reset. The check does not run while the tables are empty, and entries that complete within `THRESH` cycles never raise `hang`.
- R11: During and after reset, `dn_valid`, `done_valid`, `cpl_err` and `hang` are low and both tables are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_kind | input | 3 | Request kind code |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | LEN_W | Access length in bytes |
| rsp_status | output | 2 | 0 accept, 1 aliased, 2 full, 3 size error |
| rsp_id | output | ID_W | Number an accept takes this cycle |
| dn_valid | output | 1 | Forwarded request valid |
| dn_kind | output | 3 | Forwarded kind |
| dn_line | output | ADDR_W-OFF_W | Forwarded line address |
| dn_id | output | ID_W | Forwarded sequence number |
| cpl_valid | input | 1 | Completion presented |
| cpl_is_write | input | 1 | Completion targets the write table |
| cpl_line | input | ADDR_W-OFF_W | Completed line address |
| done_valid | output | 1 | Completion matched and retired |
| done_id | output | ID_W | Number of the retired request |
| done_lat | output | TS_W | Cycles the request was outstanding |
| cpl_err | output | 1 | Completion matched nothing |
| hang | output | 1 | Sticky stale-entry flag |

## Verification
On every cycle the assertions check the count bookkeeping. The count must equal the sum of the table occupancies and stay within its bound. An accept must raise it by one. A failed completion must leave it unchanged and produce no retire pulse. The hang flag may only rise while something is outstanding and must stay high once set. Only the bench scenarios can show the rest: which table each kind lands in, the status priority across the full sweep of offsets and lengths, exact latency values, sequence numbering, and the fact that a stale entry is flagged while short-lived ones are not.

// File: rtl/trk_pkg.sv
package trk_pkg;

  typedef enum logic [1:0] {
    ST_ACCEPT  = 2'd0,
    ST_ALIAS   = 2'd1,
    ST_FULL    = 2'd2,
    ST_BADSIZE = 2'd3
  } trk_status_e;

  // kinds that need the write table: store, atomic rd/wr, locked rd/wr
  function automatic logic kind_is_write(input logic [2:0] kind);
    return (kind >= 3'd2) && (kind <= 3'd6);
  endfunction

endpackage

// File: rtl/trk_table.sv
module trk_table #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 26,
  parameter int ID_W   = 16,
  parameter int TS_W   = 20,
  parameter int THRESH = 1000,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] probe_line,
  output logic              probe_hit,
  output logic              has_free,
  input  logic              alloc_en,
  input  logic [LINE_W-1:0] alloc_line,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic [TS_W-1:0]   alloc_ts,
  input  logic [LINE_W-1:0] free_line,
  input  logic              free_en,
  output logic              free_hit,
  output logic [ID_W-1:0]   free_id,
  output logic [TS_W-1:0]   free_ts,
  input  logic [TS_W-1:0]   now,
  output logic              stale,
  output logic [OCC_W-1:0]  occ
);

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [TS_W-1:0]   ts_q   [DEPTH];
  logic [DEPTH-1:0]  probe_m, free_m, old_m, slot_sel;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [TS_W-1:0] age;
    assign age        = now - ts_q[g];
    assign probe_m[g] = vld_q[g] && (line_q[g] == probe_line);
    assign free_m[g]  = vld_q[g] && (line_q[g] == free_line);
    assign old_m[g]   = vld_q[g] && (age >= TS_W'(THRESH));

    always_ff @(posedge clk) begin
      if (alloc_en && slot_sel[g]) begin
        line_q[g] <= alloc_line;
        id_q[g]   <= alloc_id;
        ts_q[g]   <= alloc_ts;
      end
    end
  end

  // lowest free slot wins
  always_comb begin
    logic found;
    found    = 1'b0;
    slot_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !found) begin
        slot_sel[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  // lines are unique, so at most one match; OR-reduce its fields
  always_comb begin
    free_id = '0;
    free_ts = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_m[i]) begin
        free_id = free_id | id_q[i];
        free_ts = free_ts | ts_q[i];
      end
    end
  end

  assign probe_hit = |probe_m;
  assign free_hit  = |free_m;
  assign has_free  = |(~vld_q);
  assign stale     = |old_m;
  assign occ       = OCC_W'($countones(vld_q));

  always_comb begin
    vld_d = vld_q;
    if (free_en)  vld_d = vld_d & ~free_m;
    if (alloc_en) vld_d = vld_d | slot_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

endmodule

// File: rtl/trk_watchdog.sv
module trk_watchdog #(
  parameter int THRESH = 1000,
  localparam int WD_W  = $clog2(THRESH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic stale_any,
  output logic hang
);

  logic [WD_W-1:0] wd_q, wd_d;
  logic            hang_q, hang_d;
  logic            probe;

  assign probe = busy && (wd_q == WD_W'(THRESH - 1));

  always_comb begin
    if (!busy)      wd_d = '0;
    else if (probe) wd_d = '0;
    else            wd_d = wd_q + WD_W'(1);
    hang_d = hang_q | (probe & stale_any);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q   <= '0;
      hang_q <= 1'b0;
    end else begin
      wd_q   <= wd_d;
      hang_q <= hang_d;
    end
  end

  assign hang = hang_q;

endmodule

// File: rtl/inflight_tracker.sv
module inflight_tracker
  import trk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 6,
  parameter int LEN_W    = 7,
  parameter int RD_DEPTH = 8,
  parameter int WR_DEPTH = 8,
  parameter int MAX_OUT  = 12,
  parameter int ID_W     = 16,
  parameter int TS_W     = 20,
  parameter int THRESH   = 100000,
  localparam int LINE_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic [1:0]        rsp_status,
  output logic [ID_W-1:0]   rsp_id,
  output logic              dn_valid,
  output logic [2:0]        dn_kind,
  output logic [LINE_W-1:0] dn_line,
  output logic [ID_W-1:0]   dn_id,
  input  logic              cpl_valid,
  input  logic              cpl_is_write,
  input  logic [LINE_W-1:0] cpl_line,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  output logic [TS_W-1:0]   done_lat,
  output logic              cpl_err,
  output logic              hang
);

  localparam int CNT_W    = $clog2(MAX_OUT + 1);
  localparam int SPAN_W   = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 1;
  localparam int LINE_B   = 2 ** OFF_W;
  localparam int RD_OCC_W = $clog2(RD_DEPTH + 1);
  localparam int WR_OCC_W = $clog2(WR_DEPTH + 1);

  logic [LINE_W-1:0]   req_line;
  logic [SPAN_W-1:0]   span;
  logic                size_bad, is_wr, alias_hit, no_room;
  trk_status_e         status;
  logic                accept, cpl_hit, cpl_ok;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [ID_W-1:0]     id_q, id_d;
  logic [TS_W-1:0]     now_q;
  logic                rd_hit, wr_hit, rd_room, wr_room;
  logic                rd_fhit, wr_fhit, rd_stale, wr_stale;
  logic [ID_W-1:0]     rd_fid, wr_fid, cpl_id;
  logic [TS_W-1:0]     rd_fts, wr_fts, cpl_ts;
  logic [RD_OCC_W-1:0] rd_occ;
  logic [WR_OCC_W-1:0] wr_occ;

  // ---------------- request decode ----------------
  assign req_line  = req_addr[ADDR_W-1:OFF_W];
  assign span      = SPAN_W'(req_addr[OFF_W-1:0]) + SPAN_W'(req_len);
  assign size_bad  = span > SPAN_W'(LINE_B);
  assign is_wr     = kind_is_write(req_kind);
  assign alias_hit = rd_hit | wr_hit;
  assign no_room   = (cnt_q >= CNT_W'(MAX_OUT)) | (is_wr ? !wr_room : !rd_room);

  always_comb begin
    if (size_bad)       status = ST_BADSIZE;
    else if (alias_hit) status = ST_ALIAS;
    else if (no_room)   status = ST_FULL;
    else                status = ST_ACCEPT;
  end

  assign rsp_status = status;
  assign rsp_id     = id_q;
  assign accept     = req_valid && (status == ST_ACCEPT);

  // ---------------- completion decode ----------------
  assign cpl_hit = cpl_is_write ? wr_fhit : rd_fhit;
  assign cpl_id  = cpl_is_write ? wr_fid  : rd_fid;
  assign cpl_ts  = cpl_is_write ? wr_fts  : rd_fts;
  assign cpl_ok  = cpl_valid && cpl_hit;

  // ---------------- tables ----------------
  trk_table #(
    .DEPTH(RD_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .TS_W(TS_W), .THRESH(THRESH)
  ) u_rd_tbl (
    .clk(clk), .rst_n(rst_n),
    .probe_line(req_line), .probe_hit(rd_hit), .has_free(rd_room),
    .alloc_en(accept && !is_wr), .alloc_line(req_line), .alloc_id(id_q), .alloc_ts(now_q),
    .free_line(cpl_line), .free_en(cpl_ok && !cpl_is_write), .free_hit(rd_fhit),
    .free_id(rd_fid), .free_ts(rd_fts),
    .now(now_q), .stale(rd_stale), .occ(rd_occ)
  );

  trk_table #(
    .DEPTH(WR_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .TS_W(TS_W), .THRESH(THRESH)
  ) u_wr_tbl (
    .clk(clk), .rst_n(rst_n),
    .probe_line(req_line), .probe_hit(wr_hit), .has_free(wr_room),
    .alloc_en(accept && is_wr), .alloc_line(req_line), .alloc_id(id_q), .alloc_ts(now_q),
    .free_line(cpl_line), .free_en(cpl_ok && cpl_is_write), .free_hit(wr_fhit),
    .free_id(wr_fid), .free_ts(wr_fts),
    .now(now_q), .stale(wr_stale), .occ(wr_occ)
  );

  trk_watchdog #(.THRESH(THRESH)) u_wd (
    .clk(clk), .rst_n(rst_n),
    .busy(cnt_q != '0), .stale_any(rd_stale | wr_stale), .hang(hang)
  );

  // ---------------- counters ----------------
  always_comb begin
    cnt_d = cnt_q + CNT_W'(accept) - CNT_W'(cpl_ok);
    id_d  = id_q + ID_W'(accept);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      id_q       <= '0;
      now_q      <= '0;
      dn_valid   <= 1'b0;
      done_valid <= 1'b0;
      cpl_err    <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      id_q       <= id_d;
      now_q      <= now_q + TS_W'(1);
      dn_valid   <= accept;
      done_valid <= cpl_ok;
      cpl_err    <= cpl_valid && !cpl_hit;
    end
  end

  // payload registers: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      dn_kind <= req_kind;
      dn_line <= req_line;
      dn_id   <= id_q;
    end
    if (cpl_ok) begin
      done_id  <= cpl_id;
      done_lat <= now_q - cpl_ts;
    end
  end

endmodule

// File: rtl/trk_checker.sv
module trk_checker #(
  parameter int MAX_OUT  = 12,
  parameter int RD_DEPTH = 8,
  parameter int WR_DEPTH = 8,
  localparam int CNT_W    = $clog2(MAX_OUT + 1),
  localparam int RD_OCC_W = $clog2(RD_DEPTH + 1),
  localparam int WR_OCC_W = $clog2(WR_DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [1:0]          rsp_status,
  input logic                cpl_valid,
  input logic                cpl_err,
  input logic                done_valid,
  input logic                hang,
  input logic [CNT_W-1:0]    cnt_q,
  input logic [RD_OCC_W-1:0] rd_occ,
  input logic [WR_OCC_W-1:0] wr_occ
);

  AST_CNT_EQ_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) == int'(rd_occ) + int'(wr_occ));  // R9

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= MAX_OUT);  // R9

  AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_status == 2'd0 && !cpl_valid) |=> cnt_q == $past(cnt_q) + CNT_W'(1));  // R9

  AST_ACCEPT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_status == 2'd0) |-> int'(cnt_q) < MAX_OUT);  // R3

  AST_ERR_NO_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_err |-> !done_valid);  // R8

  AST_ERR_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_err && !$past(req_valid && rsp_status == 2'd0)) |-> cnt_q == $past(cnt_q));  // R8

  AST_HANG_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hang) |-> $past(cnt_q) != '0);  // R10

  AST_HANG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hang |=> hang);  // R10

endmodule

bind inflight_tracker trk_checker #(
  .MAX_OUT(MAX_OUT), .RD_DEPTH(RD_DEPTH), .WR_DEPTH(WR_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_status(rsp_status),
  .cpl_valid(cpl_valid), .cpl_err(cpl_err), .done_valid(done_valid), .hang(hang),
  .cnt_q(cnt_q), .rd_occ(rd_occ), .wr_occ(wr_occ)
);

// File: tb/inflight_tracker_tb.sv
module inflight_tracker_tb;

  localparam int ADDR_W = 12, OFF_W = 4, LEN_W = 5, RD_D = 2, WR_D = 2;
  localparam int MAXO = 3, ID_W = 8, TS_W = 12, THR = 32;
  localparam int LINE_W = ADDR_W - OFF_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid, cpl_valid, cpl_is_write;
  logic [2:0]        req_kind;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic [LINE_W-1:0] cpl_line;
  logic [1:0]        rsp_status;
  logic [ID_W-1:0]   rsp_id, dn_id, done_id;
  logic              dn_valid, done_valid, cpl_err, hang;
  logic [2:0]        dn_kind;
  logic [LINE_W-1:0] dn_line;
  logic [TS_W-1:0]   done_lat;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int exp_id = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  inflight_tracker #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .RD_DEPTH(RD_D), .WR_DEPTH(WR_D),
    .MAX_OUT(MAXO), .ID_W(ID_W), .TS_W(TS_W), .THRESH(THR)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .rsp_status(rsp_status), .rsp_id(rsp_id),
    .dn_valid(dn_valid), .dn_kind(dn_kind), .dn_line(dn_line), .dn_id(dn_id),
    .cpl_valid(cpl_valid), .cpl_is_write(cpl_is_write), .cpl_line(cpl_line),
    .done_valid(done_valid), .done_id(done_id), .done_lat(done_lat),
    .cpl_err(cpl_err), .hang(hang)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int wr_kind(input int k);
    return (k >= 2 && k <= 6) ? 1 : 0;
  endfunction

  // status only, request withdrawn before the edge
  task automatic probe(input int kind, input int line, input int off, input int len,
                       input int exp_st, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'(kind);
    req_addr = ADDR_W'((line << OFF_W) | off); req_len = LEN_W'(len);
    #1;
    chk(rsp_status == 2'(exp_st), req, int'(rsp_status), exp_st);
    req_valid = 1'b0;
  endtask

  task automatic send(input int kind, input int line, input int off, input int len,
                      input int exp_st, output int t_acc, output int id);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'(kind);
    req_addr = ADDR_W'((line << OFF_W) | off); req_len = LEN_W'(len);
    #1;
    chk(rsp_status == 2'(exp_st), "R4 status", int'(rsp_status), exp_st);
    id = int'(rsp_id);
    if (exp_st == 0) chk(rsp_id == ID_W'(exp_id), "R6 rsp_id", int'(rsp_id), exp_id);
    @(posedge clk); #1;
    t_acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_st == 0) begin
      chk(dn_valid == 1'b1, "R5 dn_valid", int'(dn_valid), 1);
      chk(dn_kind == 3'(kind) && dn_line == LINE_W'(line), "R5 dn fields",
          int'(dn_line), line);
      chk(dn_id == ID_W'(exp_id), "R5 dn_id", int'(dn_id), exp_id);
      exp_id++;
    end
    @(negedge clk);
    chk(dn_valid == 1'b0, "R5 single pulse", int'(dn_valid), 0);
  endtask

  task automatic complete(input int is_wr, input int line, input int exp_ok,
                          input int id, input int t_acc, input string req);
    int t_c;
    @(negedge clk);
    cpl_valid = 1'b1; cpl_is_write = is_wr[0]; cpl_line = LINE_W'(line);
    @(posedge clk); #1;
    t_c = cyc;
    @(negedge clk);
    cpl_valid = 1'b0;
    if (exp_ok != 0) begin
      chk(done_valid == 1'b1 && cpl_err == 1'b0, {req, " R7 retire"}, int'(done_valid), 1);
      chk(done_id == ID_W'(id), {req, " R6 done_id"}, int'(done_id), id);
      chk(done_lat == TS_W'(t_c - t_acc), {req, " R7 latency"}, int'(done_lat), t_c - t_acc);
    end else begin
      chk(cpl_err == 1'b1 && done_valid == 1'b0, {req, " R8 cpl_err"}, int'(cpl_err), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, t2, i0, i1, i2;
    rst_n = 1'b0; req_valid = 1'b0; cpl_valid = 1'b0; cpl_is_write = 1'b0;
    req_kind = '0; req_addr = '0; req_len = '0; cpl_line = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!dn_valid && !done_valid && !cpl_err && !hang, "R11 reset outputs", int'(hang), 0);
    rst_n = 1'b1;

    // R4: sweep of offset and length on an empty tracker
    for (int off = 0; off < 16; off++)
      for (int len = 0; len <= 20; len++)
        probe((off + len) % 8, 8'h05, off, len, (off + len > 16) ? 3 : 0, "R4 size sweep");

    // R1, R8, R2: each kind lands in its own table
    for (int k = 0; k < 8; k++) begin
      send(k, 8'h10 + k, 0, 4, 0, t0, i0);
      complete(1 - wr_kind(k), 8'h10 + k, 0, 0, 0, "R1 wrong table");
      probe(0, 8'h10 + k, 8, 2, 1, "R8 entry kept R2 alias");
      complete(wr_kind(k), 8'h10 + k, 1, i0, t0, "R1 right table");
    end

    // R2: aliasing across tables
    send(0, 8'h40, 3, 4, 0, t0, i0);
    probe(2, 8'h40, 9, 2, 1, "R2 store vs load");
    probe(1, 8'h40, 0, 1, 1, "R2 fetch vs load");
    probe(0, 8'h41, 0, 1, 0, "R2 other line");
    complete(0, 8'h40, 1, i0, t0, "R2");
    probe(2, 8'h40, 0, 1, 0, "R2 freed line");

    // R3 count limit and R4 priority
    send(0, 8'h50, 0, 4, 0, t0, i0);
    send(1, 8'h51, 0, 4, 0, t1, i1);
    send(2, 8'h52, 0, 4, 0, t2, i2);
    probe(3, 8'h53, 0, 4, 2, "R3 count full");
    probe(5, 8'h54, 0, 4, 2, "R3 count full wr");
    probe(0, 8'h50, 12, 8, 3, "R4 size over alias");
    probe(4, 8'h50, 0, 8, 1, "R4 alias over full");
    complete(1, 8'h52, 1, i2, t2, "R3");
    complete(0, 8'h51, 1, i1, t1, "R3");
    complete(0, 8'h50, 1, i0, t0, "R3");

    // R3 table limit while count is below the maximum
    send(6, 8'h60, 0, 4, 0, t0, i0);
    send(3, 8'h61, 0, 4, 0, t1, i1);
    probe(4, 8'h62, 0, 4, 2, "R3 write table full");
    probe(0, 8'h62, 0, 4, 0, "R3 read table free");
    complete(1, 8'h60, 1, i0, t0, "R3");
    complete(1, 8'h61, 1, i1, t1, "R3");

    // R7: latency over several hold times
    for (int n = 0; n < 6; n++) begin
      send(n % 2, 8'h30 + n, 0, 8, 0, t0, i0);
      repeat (n) @(negedge clk);
      complete(0, 8'h30 + n, 1, i0, t0, "R7 hold");
    end

    @(negedge clk);
    chk(hang == 1'b0, "R10 no flag for short entries", int'(hang), 0);

    // R10: a stale entry raises the sticky flag
    send(0, 8'h70, 0, 4, 0, t0, i0);
    repeat (3 * THR + 4) @(negedge clk);
    chk(hang == 1'b1, "R10 stale flagged", int'(hang), 1);
    complete(0, 8'h70, 1, i0, t0, "R10");
    repeat (THR + 2) @(negedge clk);
    chk(hang == 1'b1, "R10 sticky", int'(hang), 1);

    // R11, R6: reset clears flag, tables and numbering
    rst_n = 1'b0;
    #1;
    chk(!hang && !dn_valid && !done_valid && !cpl_err, "R11 mid reset", int'(hang), 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_id = 0;
    probe(0, 8'h70, 0, 4, 0, "R11 tables empty");
    send(2, 8'h22, 0, 4, 0, t0, i0);
    chk(i0 == 0, "R6 restart at zero", i0, 0);
    complete(1, 8'h22, 1, i0, t0, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule